// File: doc/BRIEF.md
# Tagged Transmit Byte Queue

This block buffers outgoing bytes between a processor's register writes and the parallel-load input of a serial frame transmitter. Each entry holds one data byte and two marker bits. The end-of-frame marker and the abort marker are sampled from a control register at the moment the byte is written, so software can set up the markers first and then push the byte.

The transmitter asks for the next byte with a request strobe. If the queue holds data, the oldest entry is presented on the load outputs in the following cycle, together with a one-cycle load strobe. Every remaining entry then moves one place toward the head.

A write to a full queue is not dropped. It overwrites the newest entry in place. The empty flag, the full flag and the fill count are registered outputs.

Top module: `txq_tagged_fifo`

## Requirements
- R1: After reset, `empty_o`=1, `full_o`=0, `count_o`=0 and `load_o`=0. `load_data_o`, `load_eop_o` and `load_abort_o` are all 0, and every stored marker bit is cleared.
- R2: A write without a read, to a queue holding fewer than DEPTH (19) entries, raises `count_o` by one in the next cycle.
- R3: A read request to a non-empty queue asserts `load_o` for exactly the next cycle. In that cycle `load_data_o`, `load_eop_o` and `load_abort_o` show the oldest stored entry. Entries leave in the order they were written.
- R4: The marker bits of an entry are the values of `ctl_eop_i` and `ctl_abort_i` in the write cycle. Later changes on those inputs do not alter entries already stored.
- R5: A read request to an empty queue leaves `load_o` at 0 and `count_o` at 0.
- R6: A write without a read to a full queue keeps `count_o` at DEPTH and `full_o` at 1. It replaces the most recently written entry and leaves all older entries unchanged.
- R7: A read and a write in the same cycle on a non-empty queue are both carried out. `count_o` stays the same, the oldest entry is loaded, and the new word is queued behind every word already present.
- R8: A read and a write in the same cycle on an empty queue store the word and set `count_o` to 1, with `load_o` remaining 0.
- R9: `empty_o` is 1 exactly when `count_o` is 0, and `full_o` is 1 exactly when `count_o` equals DEPTH. `count_o` never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Push one byte into the queue |
| wr_data_i | input | 8 | Byte to push |
| ctl_eop_i | input | 1 | End-of-frame marker from the control register |
| ctl_abort_i | input | 1 | Frame-abort marker from the control register |
| rd_req_i | input | 1 | Transmitter requests the next byte |
| load_o | output | 1 | One-cycle strobe that loads the output shift register |
| load_data_o | output | 8 | Byte being handed to the shift register |
| load_eop_o | output | 1 | End-of-frame marker of that byte |
| load_abort_o | output | 1 | Abort marker of that byte |
| empty_o | output | 1 | Queue holds no entries |
| full_o | output | 1 | Queue holds DEPTH entries |
| count_o | output | 5 | Number of stored entries |

## Verification
A corrupt fill count shows one cycle after the faulty operation, as a wrong `count_o` or as flags that disagree with it. A misplaced write slot or a broken shift stays hidden until the entry reaches the head. It then appears as a wrong byte or wrong marker bits during the load cycle, and that can be up to DEPTH reads later. For this reason the bench drains the queue completely after every full-queue overwrite and every same-cycle read/write. It compares each loaded word with an order model, so a bad internal position surfaces at the latest when the last entry leaves.

// File: rtl/txq_pkg.sv
package txq_pkg;

   // marker bits carried with every queued byte
   typedef struct packed {
      logic abort;
      logic eop;
   } txq_tag_t;

   localparam int unsigned TAG_W = $bits(txq_tag_t);

endpackage

// File: rtl/txq_slot.sv
// One storage position of the shift-down queue. A write aimed at this
// position has priority over the shift from the position above.
module txq_slot #(
   parameter int unsigned WORD_W = 10
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              shift_i,
   input  logic [WORD_W-1:0] upper_i,
   input  logic              wr_i,
   input  logic [WORD_W-1:0] wdata_i,
   output logic [WORD_W-1:0] q_o
);

   logic [WORD_W-1:0] q_r;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         q_r <= '0;
      end else if (wr_i) begin
         q_r <= wdata_i;
      end else if (shift_i) begin
         q_r <= upper_i;
      end
   end

   assign q_o = q_r;

endmodule

// File: rtl/txq_ctrl.sv
// Occupancy bookkeeping: fill count, registered flags and write position.
module txq_ctrl #(
   parameter int unsigned DEPTH = 19,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1),
   localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_i,
   input  logic             rd_i,
   output logic             rd_fire_o,
   output logic             wr_fire_o,
   output logic [IDX_W-1:0] wpos_o,
   output logic [CNT_W-1:0] count_o,
   output logic             empty_o,
   output logic             full_o
);

   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             empty_q, full_q;
   logic             at_top, at_bottom;
   logic             grow;
   logic [CNT_W-1:0] wpos_wide;

   assign at_top    = (cnt_q == DEPTH_C);
   assign at_bottom = (cnt_q == '0);

   assign rd_fire_o = rd_i && !at_bottom;
   assign wr_fire_o = wr_i;

   // a write grows the queue unless it lands on a full queue with no read
   assign grow = wr_i && (!at_top || rd_fire_o);

   always_comb begin
      cnt_d = cnt_q;
      if (grow && !rd_fire_o) begin
         cnt_d = cnt_q + ONE_C;
      end else if (!grow && rd_fire_o) begin
         cnt_d = cnt_q - ONE_C;
      end
   end

   always_comb begin
      if (rd_fire_o) begin
         wpos_wide = cnt_q - ONE_C;
      end else if (at_top) begin
         wpos_wide = DEPTH_C - ONE_C;
      end else begin
         wpos_wide = cnt_q;
      end
   end

   assign wpos_o = wpos_wide[IDX_W-1:0];

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q   <= '0;
         empty_q <= 1'b1;
         full_q  <= 1'b0;
      end else begin
         cnt_q   <= cnt_d;
         empty_q <= (cnt_d == '0);
         full_q  <= (cnt_d == DEPTH_C);
      end
   end

   assign count_o = cnt_q;
   assign empty_o = empty_q;
   assign full_o  = full_q;

endmodule

// File: rtl/txq_out.sv
// Output register feeding the parallel load of the transmit shifter.
module txq_out #(
   parameter int unsigned DATA_W = 8,
   localparam int unsigned WORD_W = DATA_W + txq_pkg::TAG_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              fire_i,
   input  logic [WORD_W-1:0] head_i,
   output logic              load_o,
   output logic [DATA_W-1:0] data_o,
   output txq_pkg::txq_tag_t tag_o
);

   logic              load_q;
   logic [WORD_W-1:0] word_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         load_q <= 1'b0;
         word_q <= '0;
      end else begin
         load_q <= fire_i;
         if (fire_i) begin
            word_q <= head_i;
         end
      end
   end

   assign load_o = load_q;
   assign data_o = word_q[DATA_W-1:0];
   assign tag_o  = txq_pkg::txq_tag_t'(word_q[WORD_W-1:DATA_W]);

endmodule

// File: rtl/txq_tagged_fifo.sv
module txq_tagged_fifo #(
   parameter int unsigned DEPTH  = 19,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
   localparam int unsigned IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned WORD_W = DATA_W + txq_pkg::TAG_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              ctl_eop_i,
   input  logic              ctl_abort_i,
   input  logic              rd_req_i,
   output logic              load_o,
   output logic [DATA_W-1:0] load_data_o,
   output logic              load_eop_o,
   output logic              load_abort_o,
   output logic              empty_o,
   output logic              full_o,
   output logic [CNT_W-1:0]  count_o
);

   // elaboration-time parameter checks
   if (DEPTH < 2) begin : g_bad_depth
      $error("txq_tagged_fifo: DEPTH must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("txq_tagged_fifo: DATA_W must be at least 1");
   end

   logic                rd_fire, wr_fire;
   logic [IDX_W-1:0]    wpos;
   logic [WORD_W-1:0]   slot_q [DEPTH];
   logic [WORD_W-1:0]   wword;
   txq_pkg::txq_tag_t   wtag, out_tag;

   assign wtag.eop   = ctl_eop_i;
   assign wtag.abort = ctl_abort_i;
   assign wword      = {wtag, wr_data_i};

   txq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wr_en_i),
      .rd_i      (rd_req_i),
      .rd_fire_o (rd_fire),
      .wr_fire_o (wr_fire),
      .wpos_o    (wpos),
      .count_o   (count_o),
      .empty_o   (empty_o),
      .full_o    (full_o)
   );

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [WORD_W-1:0] upper;
      logic              hit;

      if (i == DEPTH - 1) begin : g_top
         assign upper = '0;
      end else begin : g_mid
         assign upper = slot_q[i+1];
      end

      assign hit = wr_fire && (wpos == IDX_W'(i));

      txq_slot #(.WORD_W(WORD_W)) u_slot (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .shift_i (rd_fire),
         .upper_i (upper),
         .wr_i    (hit),
         .wdata_i (wword),
         .q_o     (slot_q[i])
      );
   end

   txq_out #(.DATA_W(DATA_W)) u_out (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .fire_i (rd_fire),
      .head_i (slot_q[0]),
      .load_o (load_o),
      .data_o (load_data_o),
      .tag_o  (out_tag)
   );

   assign load_eop_o   = out_tag.eop;
   assign load_abort_o = out_tag.abort;

endmodule

// File: rtl/txq_tagged_fifo_chk.sv
module txq_tagged_fifo_chk #(
   parameter int unsigned DEPTH = 19,
   parameter int unsigned CNT_W = 5
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             wr_en_i,
   input logic             rd_req_i,
   input logic             load_o,
   input logic             empty_o,
   input logic             full_o,
   input logic [CNT_W-1:0] count_o
);

   p_flags_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (empty_o == (count_o == '0)) && (full_o == (count_o == CNT_W'(DEPTH))));

   p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      count_o <= CNT_W'(DEPTH));

   p_count_inc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && !rd_req_i && !full_o) |=> (count_o == $past(count_o) + CNT_W'(1)));

   p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_req_i && !empty_o) |=> load_o);

   p_empty_rd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_req_i && empty_o) |=> !load_o);

   p_full_wr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && !rd_req_i && full_o) |=> (full_o && $stable(count_o)));

   p_rw_same_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && rd_req_i && !empty_o) |=> $stable(count_o));

   p_rw_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && rd_req_i && empty_o) |=> (count_o == CNT_W'(1)));

endmodule

bind txq_tagged_fifo txq_tagged_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .wr_en_i  (wr_en_i),
   .rd_req_i (rd_req_i),
   .load_o   (load_o),
   .empty_o  (empty_o),
   .full_o   (full_o),
   .count_o  (count_o)
);

// File: tb/tb_txq_tagged_fifo.sv
`timescale 1ns/1ps
module tb_txq_tagged_fifo;

   localparam int DEPTH = 19;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       eop = 1'b0;
   logic       abrt = 1'b0;
   logic       rd_req = 1'b0;
   logic       load;
   logic [7:0] ld_data;
   logic       ld_eop, ld_abort, empty, full;
   logic [4:0] count;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   // model: {abort, eop, data}
   logic [9:0] mq[$];

   always #2.5 clk = ~clk;

   txq_tagged_fifo dut (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
      .ctl_eop_i(eop), .ctl_abort_i(abrt), .rd_req_i(rd_req),
      .load_o(load), .load_data_o(ld_data), .load_eop_o(ld_eop),
      .load_abort_o(ld_abort), .empty_o(empty), .full_o(full), .count_o(count)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // one cycle of stimulus, model update and port checks
   task automatic do_op(input string req, input bit w, input logic [7:0] d,
                        input bit e, input bit a, input bit r);
      bit         exp_ld;
      logic [9:0] exp_word;
      exp_ld = r && (mq.size() > 0);
      exp_word = '0;
      if (exp_ld) exp_word = mq.pop_front();
      if (w) begin
         if (mq.size() == DEPTH) mq[DEPTH-1] = {a, e, d};
         else mq.push_back({a, e, d});
      end
      wr_en = w; wr_data = d; eop = e; abrt = a; rd_req = r;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; rd_req = 1'b0;
      chk(req, "load", 32'(load), 32'(exp_ld));
      if (exp_ld) begin
         chk(req, "word", 32'({ld_abort, ld_eop, ld_data}), 32'(exp_word));
      end
      chk(req, "count", 32'(count), 32'(mq.size()));
      chk("R9", "empty", 32'(empty), 32'(mq.size() == 0));
      chk("R9", "full", 32'(full), 32'(mq.size() == DEPTH));
   endtask

   task automatic drain(input string req);
      while (mq.size() > 0) do_op(req, 0, 8'h00, 0, 0, 1);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      mq.delete();
      chk("R1", "empty", 32'(empty), 1);
      chk("R1", "full", 32'(full), 0);
      chk("R1", "count", 32'(count), 0);
      chk("R1", "load", 32'(load), 0);
      chk("R1", "outword", 32'({ld_abort, ld_eop, ld_data}), 0);
   endtask

   task automatic t_basic;
      do_op("R2", 1, 8'h11, 1, 0, 0);
      do_op("R2", 1, 8'h22, 0, 1, 0);
      do_op("R2", 1, 8'h33, 1, 1, 0);
      // markers change with no write: R4 stored tags must not follow
      eop = 1'b0; abrt = 1'b0;
      @(negedge clk);
      do_op("R4", 0, 8'h00, 0, 0, 0);
      do_op("R3", 0, 8'h00, 1, 1, 1);
      do_op("R4", 1, 8'h44, 0, 0, 0);
      drain("R3");
   endtask

   task automatic t_empty_read;
      do_op("R5", 0, 8'h00, 0, 0, 1);
      do_op("R5", 0, 8'h00, 0, 0, 1);
   endtask

   task automatic t_full;
      for (int i = 0; i < DEPTH; i++) do_op("R2", 1, 8'(8'h80 + i), i[0], i[1], 0);
      do_op("R6", 1, 8'hEE, 1, 0, 0);
      do_op("R6", 1, 8'hEF, 0, 1, 0);
      drain("R6");
   endtask

   task automatic t_simul;
      do_op("R2", 1, 8'hA1, 0, 0, 0);
      do_op("R2", 1, 8'hA2, 1, 0, 0);
      do_op("R2", 1, 8'hA3, 0, 1, 0);
      do_op("R7", 1, 8'hA4, 1, 1, 1);
      do_op("R7", 1, 8'hA5, 0, 0, 1);
      drain("R7");
      // full queue with same-cycle read and write
      for (int i = 0; i < DEPTH; i++) do_op("R2", 1, 8'(8'h40 + i), 0, 0, 0);
      do_op("R7", 1, 8'hC7, 1, 0, 1);
      drain("R7");
   endtask

   task automatic t_simul_empty;
      do_op("R8", 1, 8'h5A, 0, 1, 1);
      drain("R8");
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_basic();
      t_empty_read();
      t_full();
      t_simul();
      t_simul_empty();
      // fill partly, reset, check cleared state again
      do_op("R2", 1, 8'h77, 1, 1, 0);
      t_reset();
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule